// File: doc/BRIEF.md
# Self-Synchronizing Link Lock Monitor

This block brings up one receive lane of a serial link without any exchange of status with the far end. It watches the decoded character stream from the transceiver. Each character comes with a valid strobe and a code-error flag. The block decides when the lane is locked from those characters alone. Lock is gained only after a long run of clean characters. It is lost after a short run of consecutive bad characters. Until the transceiver reports that its reset sequence is complete, including PLL lock to the reference clock, the receive stream is ignored.

A small transmit-side selector sits beside the lock logic. While the host holds the force-train input, the selector sends a two-character training pattern: a comma control character followed by a fixed data character. Otherwise it forwards the host's characters. When the lane drops out of lock, the block raises a one-cycle loss pulse. A host can use this pulse to hold force-train again until the far receiver relocks. A saturating counter reports how many erroneous characters were received. Only one lane is supported.

Top module: `selfsync_lsm`

## Requirements
- R1: While `rst` is high, or on any clock where `xcvr_ready` is low, the machine returns to its waiting state. On that edge `link_up`, `link_lost` and `err_count` go to zero and both run counters are cleared.
- R2: A character presented while the machine is waiting is ignored. This includes the first cycle in which `xcvr_ready` is high. Such a character counts toward neither the clean run nor `err_count`.
- R3: While hunting, `link_up` rises on the clock edge that accepts the 64th consecutive clean character. A clean character has `rx_valid`=1 and `rx_code_err`=0.
- R4: While hunting, a valid character with `rx_code_err`=1 sets the clean run back to zero.
- R5: A cycle with `rx_valid`=0 leaves the clean run and the error run unchanged, whatever `rx_code_err` is.
- R6: While locked, `link_up` falls on the edge that accepts the 4th consecutive valid erroneous character. The machine then returns to hunting.
- R7: While locked, a valid clean character sets the error run back to zero.
- R8: `link_lost` is high for exactly the one cycle after a drop from locked to hunting. It stays low when the lock is lost through R1.
- R9: `err_count` increments on each valid erroneous character accepted outside the waiting state. It saturates at 2^ERR_W-1.
- R10: While `force_train` is high, the transmit outputs alternate, each one cycle after the input is sampled. The first value is {`tx_ctrl_out`=1, `tx_char_out`=8'hBC}. The second is {0, 8'h4A}. A new assertion of `force_train` always starts with the 8'hBC comma.
- R11: While `force_train` is low, `tx_char_out` and `tx_ctrl_out` repeat `tx_char_in` and `tx_ctrl_in` one cycle later. Reset sets both outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| xcvr_ready | input | 1 | Transceiver reset sequence done and PLL locked |
| rx_valid | input | 1 | A received character is present this cycle |
| rx_code_err | input | 1 | The present received character has a code error |
| force_train | input | 1 | Send the training pattern while high |
| tx_char_in | input | 8 | Host transmit character |
| tx_ctrl_in | input | 1 | Host transmit character is a control character |
| link_up | output | 1 | Lane is locked |
| link_lost | output | 1 | One-cycle pulse after a drop from locked to hunting |
| err_count | output | ERR_W | Saturating count of erroneous received characters |
| tx_char_out | output | 8 | Character to the transmit encoder |
| tx_ctrl_out | output | 1 | Control flag to the transmit encoder |

## Verification
The assertions check the following on every cycle:
- A rise of lock follows a clean character, and a fall follows an error, a reset or a not-ready transceiver.
- The loss pulse lasts one cycle and coincides with the fall of lock.
- Lock never survives a not-ready cycle.
- The error count never decreases between clears.
- Each new training burst opens with the comma.

Only the bench scenarios can show the exact run lengths and the counter behaviour across gaps:
- The 64th versus the 63rd clean character, and the ignored first ready cycle.
- The 4-error drop with a clean character in between.
- The clean run cleared by an error, and the counters unchanged across invalid cycles.
- Saturation of the error count, and the alternating training pattern.

The bench runs these directed cases and a long random stream against a reference model.

// File: rtl/lsm_pkg.sv
package lsm_pkg;

    localparam int CHAR_W = 8;

    // training pattern: comma control character, then a fixed data character
    localparam logic [CHAR_W-1:0] TRAIN_COMMA = 8'hBC;
    localparam logic [CHAR_W-1:0] TRAIN_FILL  = 8'h4A;

    typedef enum logic [1:0] {
        ST_WAIT = 2'd0,
        ST_HUNT = 2'd1,
        ST_UP   = 2'd2
    } lsm_state_e;

    typedef struct packed {
        lsm_state_e st;
        logic       up;
        logic       lost;
    } lsm_fsm_s;

    typedef struct packed {
        logic              ctrl;
        logic [CHAR_W-1:0] chr;
    } tx_sym_s;

endpackage

// File: rtl/lsm_run_counter.sv
// Counts a run of qualifying events; flags when the next step completes the run.
module lsm_run_counter #(
    parameter int LIMIT = 64,
    localparam int CW   = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic step,
    output logic last
);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (step) begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign last = (cnt_q == CW'(LIMIT - 1));

endmodule

// File: rtl/lsm_err_tally.sv
// Saturating counter of erroneous received characters.
module lsm_err_tally #(
    parameter int ERR_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    output logic [ERR_W-1:0] count
);

    logic [ERR_W-1:0] tally_d, tally_q;

    always_comb begin
        tally_d = tally_q;
        if (inc && (tally_q != {ERR_W{1'b1}})) begin
            tally_d = tally_q + ERR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tally_q <= '0;
        end else begin
            tally_q <= tally_d;
        end
    end

    assign count = tally_q;

endmodule

// File: rtl/lsm_train_gen.sv
// Transmit selector: training pattern while forced, host traffic otherwise.
module lsm_train_gen
    import lsm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              force_train,
    input  logic [CHAR_W-1:0] char_in,
    input  logic              ctrl_in,
    output logic [CHAR_W-1:0] char_out,
    output logic              ctrl_out
);

    typedef struct packed {
        tx_sym_s sym;
        logic    phase;
    } gen_s;

    gen_s gen_d, gen_q;

    always_comb begin
        gen_d = gen_q;
        if (force_train) begin
            if (gen_q.phase) begin
                gen_d.sym.ctrl = 1'b0;
                gen_d.sym.chr  = TRAIN_FILL;
            end else begin
                gen_d.sym.ctrl = 1'b1;
                gen_d.sym.chr  = TRAIN_COMMA;
            end
            gen_d.phase = ~gen_q.phase;
        end else begin
            gen_d.sym.ctrl = ctrl_in;
            gen_d.sym.chr  = char_in;
            gen_d.phase    = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gen_q <= '0;
        end else begin
            gen_q <= gen_d;
        end
    end

    assign char_out = gen_q.sym.chr;
    assign ctrl_out = gen_q.sym.ctrl;

endmodule

// File: rtl/selfsync_lsm.sv
module selfsync_lsm
    import lsm_pkg::*;
#(
    parameter int GOOD_RUN = 64,
    parameter int BAD_RUN  = 4,
    parameter int ERR_W    = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              xcvr_ready,
    input  logic              rx_valid,
    input  logic              rx_code_err,
    input  logic              force_train,
    input  logic [CHAR_W-1:0] tx_char_in,
    input  logic              tx_ctrl_in,
    output logic              link_up,
    output logic              link_lost,
    output logic [ERR_W-1:0]  err_count,
    output logic [CHAR_W-1:0] tx_char_out,
    output logic              tx_ctrl_out
);

    lsm_fsm_s fsm_d, fsm_q;

    logic hold;
    logic clean_chr, bad_chr;
    logic good_step, good_clr, good_last;
    logic bad_step, bad_clr, bad_last;
    logic tally_inc;

    // anything that returns the machine to waiting
    assign hold      = rst || !xcvr_ready;
    assign clean_chr = rx_valid && !rx_code_err;
    assign bad_chr   = rx_valid && rx_code_err;

    assign good_step = (fsm_q.st == ST_HUNT) && clean_chr;
    assign good_clr  = (fsm_q.st != ST_HUNT) || bad_chr || (good_step && good_last);
    assign bad_step  = (fsm_q.st == ST_UP) && bad_chr;
    assign bad_clr   = (fsm_q.st != ST_UP) || clean_chr || (bad_step && bad_last);
    assign tally_inc = (fsm_q.st != ST_WAIT) && bad_chr;

    lsm_run_counter #(.LIMIT(GOOD_RUN)) u_good_run (
        .clk  (clk),
        .rst  (hold),
        .clr  (good_clr),
        .step (good_step),
        .last (good_last)
    );

    lsm_run_counter #(.LIMIT(BAD_RUN)) u_bad_run (
        .clk  (clk),
        .rst  (hold),
        .clr  (bad_clr),
        .step (bad_step),
        .last (bad_last)
    );

    lsm_err_tally #(.ERR_W(ERR_W)) u_tally (
        .clk   (clk),
        .rst   (hold),
        .inc   (tally_inc),
        .count (err_count)
    );

    lsm_train_gen u_train (
        .clk         (clk),
        .rst         (rst),
        .force_train (force_train),
        .char_in     (tx_char_in),
        .ctrl_in     (tx_ctrl_in),
        .char_out    (tx_char_out),
        .ctrl_out    (tx_ctrl_out)
    );

    always_comb begin
        fsm_d      = fsm_q;
        fsm_d.lost = 1'b0;
        unique case (fsm_q.st)
            ST_WAIT: begin
                fsm_d.st = ST_HUNT;
            end
            ST_HUNT: begin
                if (good_step && good_last) begin
                    fsm_d.st = ST_UP;
                end
            end
            ST_UP: begin
                if (bad_step && bad_last) begin
                    fsm_d.st   = ST_HUNT;
                    fsm_d.lost = 1'b1;
                end
            end
            default: begin
                fsm_d.st = ST_WAIT;
            end
        endcase
        if (!xcvr_ready) begin
            fsm_d.st   = ST_WAIT;
            fsm_d.lost = 1'b0;
        end
        fsm_d.up = (fsm_d.st == ST_UP);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fsm_q <= '{st: ST_WAIT, up: 1'b0, lost: 1'b0};
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign link_up   = fsm_q.up;
    assign link_lost = fsm_q.lost;

endmodule

// File: rtl/selfsync_lsm_checker.sv
module selfsync_lsm_checker #(
    parameter int ERR_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             xcvr_ready,
    input logic             rx_valid,
    input logic             rx_code_err,
    input logic             force_train,
    input logic             link_up,
    input logic             link_lost,
    input logic [ERR_W-1:0] err_count,
    input logic [7:0]       tx_char_out,
    input logic             tx_ctrl_out
);

    AST_UP_AFTER_CLEAN: assert property (@(posedge clk) disable iff (rst) $rose(link_up) |-> $past(rx_valid && !rx_code_err && xcvr_ready)); // R3
    AST_DOWN_CAUSE: assert property (@(posedge clk) disable iff (rst) $fell(link_up) |-> $past(rst || !xcvr_ready || (rx_valid && rx_code_err))); // R6
    AST_NOT_READY_DROPS: assert property (@(posedge clk) disable iff (rst) !xcvr_ready |=> (!link_up && !link_lost && err_count == '0)); // R1
    AST_LOST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) link_lost |=> !link_lost); // R8
    AST_LOST_WITH_FALL: assert property (@(posedge clk) disable iff (rst) link_lost |-> (!link_up && $past(link_up))); // R8
    AST_TALLY_MONOTONIC: assert property (@(posedge clk) disable iff (rst) ($past(xcvr_ready) && !$past(rst)) |-> (err_count >= $past(err_count))); // R9
    AST_TRAIN_OPENS_COMMA: assert property (@(posedge clk) disable iff (rst) ($rose(force_train) && !rst) |=> (tx_ctrl_out && tx_char_out == 8'hBC)); // R10

endmodule

bind selfsync_lsm selfsync_lsm_checker #(.ERR_W(ERR_W)) u_lsm_checker (
    .clk         (clk),
    .rst         (rst),
    .xcvr_ready  (xcvr_ready),
    .rx_valid    (rx_valid),
    .rx_code_err (rx_code_err),
    .force_train (force_train),
    .link_up     (link_up),
    .link_lost   (link_lost),
    .err_count   (err_count),
    .tx_char_out (tx_char_out),
    .tx_ctrl_out (tx_ctrl_out)
);

// File: tb/test_selfsync_lsm.sv
module test_selfsync_lsm;

    localparam int EW = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          xcvr_ready = 1'b0;
    logic          rx_valid = 1'b0;
    logic          rx_code_err = 1'b0;
    logic          force_train = 1'b0;
    logic [7:0]    tx_char_in = '0;
    logic          tx_ctrl_in = 1'b0;
    logic          link_up, link_lost, tx_ctrl_out;
    logic [EW-1:0] err_count;
    logic [7:0]    tx_char_out;

    int total = 0;
    int fails = 0;

    // reference model state
    int   m_st = 0;          // 0 wait, 1 hunt, 2 locked
    int   m_good = 0, m_bad = 0, m_err = 0;
    bit   m_up = 0, m_lost = 0, m_ph = 0;
    logic [7:0] m_chr = '0;
    bit   m_ctrl = 0;

    always #2 clk = ~clk;

    selfsync_lsm #(.ERR_W(EW)) i_selfsync_lsm (
        .clk(clk), .rst(rst), .xcvr_ready(xcvr_ready), .rx_valid(rx_valid),
        .rx_code_err(rx_code_err), .force_train(force_train),
        .tx_char_in(tx_char_in), .tx_ctrl_in(tx_ctrl_in),
        .link_up(link_up), .link_lost(link_lost), .err_count(err_count),
        .tx_char_out(tx_char_out), .tx_ctrl_out(tx_ctrl_out)
    );

    task automatic check(string tag, string what, int act, int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic void model_step();
        int st_old = m_st;
        if (rst || !xcvr_ready) begin
            m_st = 0; m_good = 0; m_bad = 0; m_err = 0; m_up = 0; m_lost = 0;
        end else begin
            m_lost = 0;
            if (st_old != 0 && rx_valid && rx_code_err && m_err != (1 << EW) - 1) m_err++;
            case (st_old)
                0: m_st = 1;
                1: begin
                    if (rx_valid && !rx_code_err) begin
                        if (m_good == 63) begin m_st = 2; m_good = 0; end
                        else m_good++;
                    end else if (rx_valid) m_good = 0;
                end
                default: begin
                    if (rx_valid && rx_code_err) begin
                        if (m_bad == 3) begin m_st = 1; m_bad = 0; m_lost = 1; end
                        else m_bad++;
                    end else if (rx_valid) m_bad = 0;
                end
            endcase
            m_up = (m_st == 2);
        end
        if (rst) begin
            m_chr = '0; m_ctrl = 0; m_ph = 0;
        end else if (force_train) begin
            m_chr  = m_ph ? 8'h4A : 8'hBC;
            m_ctrl = !m_ph;
            m_ph   = !m_ph;
        end else begin
            m_chr = tx_char_in; m_ctrl = tx_ctrl_in; m_ph = 0;
        end
    endfunction

    // one clock: drive at negedge, model at posedge, compare 1 ns later
    task automatic cyc(bit r, bit rdy, bit v, bit e, bit ft, string tag);
        @(negedge clk);
        rst = r; xcvr_ready = rdy; rx_valid = v; rx_code_err = e; force_train = ft;
        tx_char_in = 8'($urandom); tx_ctrl_in = 1'($urandom);
        @(posedge clk);
        model_step();
        #1;
        check(tag, "link_up", int'(link_up), int'(m_up));
        check(tag, "link_lost", int'(link_lost), int'(m_lost));
        check(tag, "err_count", int'(err_count), m_err);
        check(tag, "tx_char_out", int'(tx_char_out), int'(m_chr));
        check(tag, "tx_ctrl_out", int'(tx_ctrl_out), int'(m_ctrl));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        void'($urandom(32'h1F2E));
        // R1: reset state
        repeat (3) cyc(1, 1, 1, 1, 0, "R1 reset");
        check("R1", "link_up after reset", int'(link_up), 0);
        // R2: not ready, errors ignored
        repeat (5) cyc(0, 0, 1, 1, 0, "R2 not ready");
        check("R2", "err_count while waiting", int'(err_count), 0);
        // R2/R3: first ready cycle ignored, so 64 goods from there is one short
        repeat (64) cyc(0, 1, 1, 0, 0, "R2 first ready ignored");
        check("R2", "link_up one short", int'(link_up), 0);
        cyc(0, 1, 1, 0, 0, "R3 64th clean");
        check("R3", "link_up at 64th", int'(link_up), 1);
        // R7: 3 errors, clean, 3 errors keeps lock
        repeat (3) cyc(0, 1, 1, 1, 0, "R7 errs");
        cyc(0, 1, 1, 0, 0, "R7 clean clears");
        repeat (3) cyc(0, 1, 1, 1, 0, "R7 errs again");
        check("R7", "still locked", int'(link_up), 1);
        // R5: invalid cycles with err flag do not count
        repeat (5) cyc(0, 1, 0, 1, 0, "R5 gap in error run");
        check("R5", "still locked after gap", int'(link_up), 1);
        // R6/R8: 4th error drops
        cyc(0, 1, 1, 1, 0, "R6 4th error");
        check("R6", "link_up after 4th", int'(link_up), 0);
        check("R8", "link_lost pulse", int'(link_lost), 1);
        cyc(0, 1, 0, 0, 0, "R8 pulse ends");
        check("R8", "link_lost cleared", int'(link_lost), 0);
        // R4: error breaks clean run; R5: gaps keep it
        repeat (63) cyc(0, 1, 1, 0, 0, "R4 63 clean");
        cyc(0, 1, 1, 1, 0, "R4 error in hunt");
        for (int i = 0; i < 63; i++) begin
            cyc(0, 1, 1, 0, 0, "R4 rerun");
            if (i % 9 == 0) cyc(0, 1, 0, 1, 0, "R5 gap in clean run");
        end
        check("R4", "not locked after reset run", int'(link_up), 0);
        cyc(0, 1, 1, 0, 0, "R5 64th across gaps");
        check("R5", "locked across gaps", int'(link_up), 1);
        // R1/R8: ready drop while locked, no pulse
        cyc(0, 0, 1, 0, 0, "R1 ready drop");
        check("R8", "no pulse on ready drop", int'(link_lost), 0);
        check("R1", "err_count cleared", int'(err_count), 0);
        // R9: saturation
        repeat (70) cyc(0, 1, 1, 1, 0, "R9 saturate");
        check("R9", "err_count saturated", int'(err_count), 63);
        // R10/R11: training then passthrough
        cyc(0, 1, 0, 0, 0, "R11 pass");
        repeat (6) cyc(0, 1, 0, 0, 1, "R10 train");
        repeat (3) cyc(0, 1, 0, 0, 0, "R11 pass after train");
        cyc(0, 1, 0, 0, 1, "R10 restart comma");
        check("R10", "restart is comma", int'(tx_char_out), 8'hBC);
        // random stream in segments of differing error density
        begin
            bit ft = 0;
            for (int s = 0; s < 40; s++) begin
                int mode = int'($urandom % 4);
                int pe = (mode == 0) ? 0 : (mode == 1) ? 1 : (mode == 2) ? 30 : 90;
                for (int c = 0; c < 80; c++) begin
                    bit rdy = ($urandom % 500) != 0;
                    bit v   = ($urandom % 100) < 85;
                    bit e   = int'($urandom % 100) < pe;
                    if (($urandom % 50) == 0) ft = !ft;
                    cyc(($urandom % 1500) == 0, rdy, v, e, ft, "R3 R4 R6 R9 random");
                end
            end
        end
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule